// File: doc/BRIEF.md
# Burst SRAM Access Controller

This block is the synchronous front end of a single-port burst SRAM whose data bus is shared between reads and writes. It samples its control, address and data inputs on the rising clock edge. From those samples it decides whether the cycle opens a new access, continues a running burst, or leaves the bus idle. Three chip selects gate every new access. Two address strobes can open one: a processor strobe and a controller strobe. They follow different write rules, and the processor strobe wins when both are low.

Writes are byte-granular over a word of four 8-bit lanes. A global write enable writes every lane. Otherwise a byte-write enable works together with one select per lane. Read data comes straight from the array at the current burst address, with no output register. It is driven only while output enable is low and the access is a read. The data bus is modelled as separate input, output and drive-enable ports. A separate sequencer steps a two-bit burst counter in either a linear or an interleaved order, and the controller reaches it through load and advance controls.

Top module: `sram_burst_ctrl`

## Requirements
- R1: A new access opens on a clock rise only when `sel1_n` is low, `sel2` is high and `sel3_n` is low while an effective strobe is low. A strobe seen with any select inactive is a deselect: the burst ends and `dout_en` is low after that edge.
- R2: While `sel1_n` is high, a low `pstb_n` has no effect. With `cstb_n` also low the cycle is a deselect, nothing is written, and the array keeps its contents.
- R3: When `pstb_n` is low and counts (R2), `cstb_n` is ignored. The cycle opens a read at `addr`, and its data is driven after the edge if `out_en_n` is low, even when the write inputs are active.
- R4: In the first cycle of a processor-strobe access the write inputs are ignored. If they show a write at the next clock rise with no strobe, `din` is written to the loaded address with no address advance. If they show no write, the access continues as a read.
- R5: A controller-strobe access (with `pstb_n` high) samples the write inputs in its own cycle. It writes `din` at `addr` when `gw_n` or `bwe_n` is low, and otherwise opens a read.
- R6: Lane i covers `din[8*i+7:8*i]`. A low `gw_n` writes all four lanes whatever `bwe_n` and `bsel_n` are. Otherwise lane i is written only when `bwe_n` is low and `bsel_n[i]` is low. `bwe_n` low with every select high still counts as a write that stores nothing.
- R7: After any edge that detects a write, `dout_en` is low whatever the level of `out_en_n`.
- R8: During a read, `dout` holds the word at the current burst address after the edge that set that address. `dout_en` equals the inverse of `out_en_n` combinationally, with no clock involved.
- R9: With no strobe low and `cont_n` low, an open burst moves to its next address. In linear order (`burst_ilv` low at load) the low two address bits step by +1 modulo 4, so a burst started at offset 2 visits offsets 2, 3, 0, 1. A write burst writes `din` at each new address using that cycle's lane enables.
- R10: In interleaved order (`burst_ilv` high at load) the low two address bits are the start offset XOR the step count, so a burst started at offset 1 visits offsets 1, 0, 3, 2.
- R11: With no strobe low and `cont_n` high, the burst ends and `dout_en` goes low. A later low `cont_n` with no strobe does not resume it.
- R12: Synchronous reset ends any burst. `dout_en` is low after reset, and a low `cont_n` alone does not start driving.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| sel1_n | input | 1 | First chip select, active low; also gates the processor strobe |
| sel2 | input | 1 | Second chip select, active high |
| sel3_n | input | 1 | Third chip select, active low |
| pstb_n | input | 1 | Processor address strobe, active low |
| cstb_n | input | 1 | Controller address strobe, active low |
| cont_n | input | 1 | Burst continue, active low |
| burst_ilv | input | 1 | Burst order captured at load: 0 linear, 1 interleaved |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bsel_n | input | LANES (4) | Per-lane byte selects, active low |
| out_en_n | input | 1 | Output enable, active low, combinational |
| addr | input | AW (9) | Word address |
| din | input | LANES*LANE_W (32) | Write data from the bus |
| dout | output | LANES*LANE_W (32) | Read data toward the bus |
| dout_en | output | 1 | Bus drive enable |

## Verification
On every cycle the assertions check how the strobes and selects govern the bus. A deselect, a gated processor strobe or an idle cycle always leaves `dout_en` low after the edge. A controller-strobe write always tri-states the bus, and a counted processor strobe always makes the drive follow output enable. Only the bench scenarios can show that data lands in the right lanes and addresses. These cover the deferred write of a processor-strobe access, the absence of a write in its first cycle, the linear and interleaved visiting orders, and the array contents left untouched after ignored strobes.

// File: rtl/sram_burst_pkg.sv
package sram_burst_pkg;

    localparam int BURST_CNT_W = 2;

    typedef enum logic [1:0] {
        CYC_NONE    = 2'd0,
        CYC_START_P = 2'd1,
        CYC_START_C = 2'd2,
        CYC_DESEL   = 2'd3
    } cyc_e;

    typedef struct packed {
        cyc_e kind;
        logic wr_req;
    } cmd_t;

    typedef struct packed {
        logic active;
        logic is_write;
        logic pend;
    } acc_state_t;

    localparam acc_state_t ACC_IDLE = '{active: 1'b0, is_write: 1'b0, pend: 1'b0};

    // Offset inside the burst block for a given start offset and step count.
    function automatic logic [BURST_CNT_W-1:0] burst_pos(
        input logic [BURST_CNT_W-1:0] start,
        input logic [BURST_CNT_W-1:0] step,
        input logic                   ilv
    );
        return ilv ? (start ^ step) : (start + step);
    endfunction

endpackage

// File: rtl/sram_burst_seq.sv
module sram_burst_seq
    import sram_burst_pkg::*;
#(
    parameter int AW = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          advance,
    input  logic          ilv,
    input  logic [AW-1:0] load_addr,
    output logic [AW-1:0] cur_addr,
    output logic [AW-1:0] nxt_addr
);
    localparam int CW = BURST_CNT_W;

    logic [AW-1:0] base_q;
    logic [CW-1:0] cnt_q;
    logic          ilv_q;
    logic [CW-1:0] cnt_nx;

    assign cnt_nx = cnt_q + {{(CW-1){1'b0}}, 1'b1};

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            cnt_q  <= '0;
            ilv_q  <= 1'b0;
        end else if (load) begin
            base_q <= load_addr;
            cnt_q  <= '0;
            ilv_q  <= ilv;
        end else if (advance) begin
            cnt_q  <= cnt_nx;
        end
    end

    assign cur_addr = {base_q[AW-1:CW], burst_pos(base_q[CW-1:0], cnt_q, ilv_q)};
    assign nxt_addr = {base_q[AW-1:CW], burst_pos(base_q[CW-1:0], cnt_nx, ilv_q)};

endmodule

// File: rtl/sram_cmd_decode.sv
module sram_cmd_decode
    import sram_burst_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic             sel1_n,
    input  logic             sel2,
    input  logic             sel3_n,
    input  logic             pstb_n,
    input  logic             cstb_n,
    input  logic             gw_n,
    input  logic             bwe_n,
    input  logic [LANES-1:0] bsel_n,
    output cmd_t             cmd,
    output logic [LANES-1:0] lane_we
);
    logic pstb_counts;
    logic rest_sel;

    // The processor strobe only counts behind the first select.
    assign pstb_counts = ~pstb_n & ~sel1_n;
    assign rest_sel    = sel2 & ~sel3_n;

    always_comb begin
        if (pstb_counts) begin
            cmd.kind = rest_sel ? CYC_START_P : CYC_DESEL;
        end else if (~cstb_n) begin
            cmd.kind = (~sel1_n & rest_sel) ? CYC_START_C : CYC_DESEL;
        end else begin
            cmd.kind = CYC_NONE;
        end
        cmd.wr_req = ~gw_n | ~bwe_n;
    end

    always_comb begin
        if (~gw_n)       lane_we = '1;
        else if (~bwe_n) lane_we = ~bsel_n;
        else             lane_we = '0;
    end

endmodule

// File: rtl/sram_lane_array.sv
module sram_lane_array #(
    parameter int AW     = 9,
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic [LANES-1:0]        we,
    input  logic [AW-1:0]           waddr,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic [AW-1:0]           raddr,
    output logic [LANES*LANE_W-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (we[g]) mem[waddr] <= wdata[g*LANE_W +: LANE_W];
        end

        assign rdata[g*LANE_W +: LANE_W] = mem[raddr];
    end

endmodule

// File: rtl/sram_burst_ctrl.sv
module sram_burst_ctrl
    import sram_burst_pkg::*;
#(
    parameter int AW     = 9,
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    sel1_n,
    input  logic                    sel2,
    input  logic                    sel3_n,
    input  logic                    pstb_n,
    input  logic                    cstb_n,
    input  logic                    cont_n,
    input  logic                    burst_ilv,
    input  logic                    gw_n,
    input  logic                    bwe_n,
    input  logic [LANES-1:0]        bsel_n,
    input  logic                    out_en_n,
    input  logic [AW-1:0]           addr,
    input  logic [LANES*LANE_W-1:0] din,
    output logic [LANES*LANE_W-1:0] dout,
    output logic                    dout_en
);
    localparam int DW = LANES * LANE_W;

    cmd_t             cmd;
    logic [LANES-1:0] lane_we;
    acc_state_t       st_q, st_d;
    logic             seq_load, seq_adv;
    logic [AW-1:0]    cur_addr, nxt_addr, wr_addr;
    logic [LANES-1:0] arr_we;
    logic [DW-1:0]    rd_word;

    sram_cmd_decode #(.LANES(LANES)) u_dec (
        .sel1_n (sel1_n),
        .sel2   (sel2),
        .sel3_n (sel3_n),
        .pstb_n (pstb_n),
        .cstb_n (cstb_n),
        .gw_n   (gw_n),
        .bwe_n  (bwe_n),
        .bsel_n (bsel_n),
        .cmd    (cmd),
        .lane_we(lane_we)
    );

    sram_burst_seq #(.AW(AW)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .load     (seq_load),
        .advance  (seq_adv),
        .ilv      (burst_ilv),
        .load_addr(addr),
        .cur_addr (cur_addr),
        .nxt_addr (nxt_addr)
    );

    sram_lane_array #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
        .clk  (clk),
        .we   (arr_we),
        .waddr(wr_addr),
        .wdata(din),
        .raddr(cur_addr),
        .rdata(rd_word)
    );

    always_comb begin
        st_d     = st_q;
        seq_load = 1'b0;
        seq_adv  = 1'b0;
        arr_we   = '0;
        wr_addr  = cur_addr;
        case (cmd.kind)
            CYC_START_P: begin
                // Write qualification is deferred to the next edge.
                seq_load = 1'b1;
                st_d     = '{active: 1'b1, is_write: 1'b0, pend: 1'b1};
            end
            CYC_START_C: begin
                seq_load = 1'b1;
                st_d     = '{active: 1'b1, is_write: cmd.wr_req, pend: 1'b0};
                if (cmd.wr_req) begin
                    arr_we  = lane_we;
                    wr_addr = addr;
                end
            end
            CYC_DESEL: begin
                st_d = ACC_IDLE;
            end
            default: begin
                if (st_q.active && st_q.pend && cmd.wr_req) begin
                    arr_we  = lane_we;
                    wr_addr = cur_addr;
                    st_d    = '{active: 1'b1, is_write: 1'b1, pend: 1'b0};
                end else if (st_q.active && !cont_n) begin
                    seq_adv = 1'b1;
                    st_d    = '{active: 1'b1, is_write: st_q.is_write, pend: 1'b0};
                    if (st_q.is_write) begin
                        arr_we  = lane_we;
                        wr_addr = nxt_addr;
                    end
                end else begin
                    st_d = ACC_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= ACC_IDLE;
        else     st_q <= st_d;
    end

    assign dout    = rd_word;
    assign dout_en = st_q.active & ~st_q.is_write & ~out_en_n;

endmodule

// File: rtl/sram_burst_ctrl_chk.sv
module sram_burst_ctrl_chk (
    input logic clk,
    input logic rst,
    input logic sel1_n,
    input logic sel2,
    input logic sel3_n,
    input logic pstb_n,
    input logic cstb_n,
    input logic cont_n,
    input logic gw_n,
    input logic bwe_n,
    input logic out_en_n,
    input logic dout_en
);
    logic all_sel;
    assign all_sel = ~sel1_n & sel2 & ~sel3_n;

    // R1: controller strobe with a select inactive releases the bus
    p_desel_release_r1: assert property (@(posedge clk) disable iff (rst)
        (!cstb_n && pstb_n && !all_sel) |=> !dout_en);

    // R2: processor strobe behind a high first select opens nothing
    p_pstb_gated_r2: assert property (@(posedge clk) disable iff (rst)
        (sel1_n && cstb_n && cont_n) |=> !dout_en);

    // R3: a counted processor strobe opens a read driven by output enable
    p_pstb_read_r3: assert property (@(posedge clk) disable iff (rst)
        (!pstb_n && all_sel) |=> (dout_en == !out_en_n));

    // R7: a controller-strobe write leaves the bus undriven
    p_cstb_wr_off_r7: assert property (@(posedge clk) disable iff (rst)
        (!cstb_n && pstb_n && all_sel && (!gw_n || !bwe_n)) |=> !dout_en);

    // R8: the bus is never driven while output enable is high
    p_oe_gate_r8: assert property (@(posedge clk) disable iff (rst)
        out_en_n |-> !dout_en);

    // R11: no strobe and no continue ends the burst
    p_idle_release_r11: assert property (@(posedge clk) disable iff (rst)
        (pstb_n && cstb_n && cont_n) |=> !dout_en);

endmodule

bind sram_burst_ctrl sram_burst_ctrl_chk u_chk (.*);

// File: tb/sram_burst_ctrl_test.sv
`timescale 1ns/1ps
module sram_burst_ctrl_test;

    typedef struct packed {
        logic        ilv;
        logic        s1n;
        logic        s2;
        logic        s3n;
        logic        pn;
        logic        cn;
        logic        an;
        logic        gwn;
        logic        bwen;
        logic [3:0]  bsn;
        logic        oen;
        logic [8:0]  ad;
        logic [31:0] d;
        logic        xen;
        logic        ckd;
        logic [31:0] xd;
        logic [7:0]  rq;
    } vec_t;

    localparam int NV = 44;
    // fields: ilv s1n s2 s3n pn cn an gwn bwen bsn oen ad d xen ckd xd rq
    localparam vec_t VEC [NV] = '{
        '{1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,4'hF,1'b0,9'h010,32'hA0A0A0A0,1'b0,1'b0,32'h0,8'd7},  // R7 write, oe low
        '{1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,4'hF,1'b0,9'h011,32'hFFFFFFFF,1'b0,1'b0,32'h0,8'd5},  // R5
        '{1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,1'b1,1'b0,4'hA,1'b0,9'h011,32'h11223344,1'b0,1'b0,32'h0,8'd6},  // R6 lanes 0,2
        '{1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,4'hF,1'b0,9'h012,32'h55667788,1'b0,1'b0,32'h0,8'd6},  // R6 gw override
        '{1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,4'hF,1'b0,9'h010,32'h0,1'b1,1'b1,32'hA0A0A0A0,8'd5},  // R5 read
        '{1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,4'hF,1'b0,9'h011,32'h0,1'b1,1'b1,32'hFF22FF44,8'd6},  // R6
        '{1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,4'hF,1'b0,9'h012,32'h0,1'b1,1'b1,32'h55667788,8'd6},  // R6
        '{1'b0,1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,1'b1,1'b1,4'hF,1'b0,9'h000,32'h0,1'b0,1'b0,32'h0,8'd11},        // R11 idle
        '{1'b0,1'b0,1'b1,1'b0,1'b1,1'b1,1'b0,1'b1,1'b1,4'hF,1'b0,9'h000,32'h0,1'b0,1'b0,32'h0,8'd11},        // R11 no resume
        '{1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,4'hF,1'b1,9'h010,32'h0,1'b0,1'b0,32'h0,8'd8},         // R8 oe high
        '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,4'hF,1'b0,9'h010,32'h0,1'b1,1'b1,32'hA0A0A0A0,8'd3},  // R3 priority, no write
        '{1'b0,1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,1'b0,1'b1,4'hF,1'b0,9'h000,32'h0BADF00D,1'b0,1'b0,32'h0,8'd4},  // R4 deferred write
        '{1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,4'hF,1'b0,9'h010,32'h0,1'b1,1'b1,32'h0BADF00D,8'd4},  // R4
        '{1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,4'hF,1'b0,9'h020,32'h20,1'b0,1'b0,32'h0,8'd5},        // R5 fill
        '{1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,4'hF,1'b0,9'h021,32'h21,1'b0,1'b0,32'h0,8'd5},
        '{1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,4'hF,1'b0,9'h022,32'h22,1'b0,1'b0,32'h0,8'd5},
        '{1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,4'hF,1'b0,9'h023,32'h23,1'b0,1'b0,32'h0,8'd5},
        '{1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,4'hF,1'b0,9'h022,32'h0,1'b1,1'b1,32'h22,8'd9},        // R9 linear
        '{1'b0,1'b0,1'b1,1'b0,1'b1,1'b1,1'b0,1'b1,1'b1,4'hF,1'b0,9'h000,32'h0,1'b1,1'b1,32'h23,8'd9},
        '{1'b0,1'b0,1'b1,1'b0,1'b1,1'b1,1'b0,1'b1,1'b1,4'hF,1'b0,9'h000,32'h0,1'b1,1'b1,32'h20,8'd9},        // R9 wrap
        '{1'b0,1'b0,1'b1,1'b0,1'b1,1'b1,1'b0,1'b1,1'b1,4'hF,1'b0,9'h000,32'h0,1'b1,1'b1,32'h21,8'd9},
        '{1'b1,1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,4'hF,1'b0,9'h021,32'h0,1'b1,1'b1,32'h21,8'd10},       // R10 interleaved
        '{1'b1,1'b0,1'b1,1'b0,1'b1,1'b1,1'b0,1'b1,1'b1,4'hF,1'b0,9'h000,32'h0,1'b1,1'b1,32'h20,8'd10},
        '{1'b1,1'b0,1'b1,1'b0,1'b1,1'b1,1'b0,1'b1,1'b1,4'hF,1'b0,9'h000,32'h0,1'b1,1'b1,32'h23,8'd10},
        '{1'b1,1'b0,1'b1,1'b0,1'b1,1'b1,1'b0,1'b1,1'b1,4'hF,1'b0,9'h000,32'h0,1'b1,1'b1,32'h22,8'd10},
        '{1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,4'hF,1'b0,9'h030,32'h30,1'b0,1'b0,32'h0,8'd9},        // R9 write burst
        '{1'b0,1'b0,1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,1'b1,4'hF,1'b0,9'h000,32'h31,1'b0,1'b0,32'h0,8'd9},
        '{1'b0,1'b0,1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,1'b1,4'hF,1'b0,9'h000,32'h32,1'b0,1'b0,32'h0,8'd7},        // R7
        '{1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,4'hF,1'b0,9'h031,32'h0,1'b1,1'b1,32'h31,8'd9},
        '{1'b0,1'b0,1'b1,1'b0,1'b1,1'b1,1'b0,1'b1,1'b1,4'hF,1'b0,9'h000,32'h0,1'b1,1'b1,32'h32,8'd9},
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b1,1'b1,4'hF,1'b0,9'h030,32'h0,1'b0,1'b0,32'h0,8'd1},         // R1 sel2 low
        '{1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,4'hF,1'b0,9'h030,32'h0,1'b1,1'b1,32'h30,8'd1},
        '{1'b0,1'b0,1'b1,1'b1,1'b1,1'b0,1'b1,1'b1,1'b1,4'hF,1'b0,9'h030,32'h0,1'b0,1'b0,32'h0,8'd1},         // R1 sel3 high
        '{1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,4'hF,1'b0,9'h010,32'h0,1'b1,1'b1,32'h0BADF00D,8'd2},
        '{1'b0,1'b1,1'b1,1'b0,1'b0,1'b1,1'b1,1'b1,1'b1,4'hF,1'b0,9'h010,32'h0,1'b0,1'b0,32'h0,8'd2},         // R2 gated
        '{1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,4'hF,1'b0,9'h010,32'hDEADBEEF,1'b0,1'b0,32'h0,8'd2},  // R2 no write
        '{1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,4'hF,1'b0,9'h010,32'h0,1'b1,1'b1,32'h0BADF00D,8'd2},
        '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,1'b1,1'b1,1'b1,4'hF,1'b0,9'h020,32'h0,1'b1,1'b1,32'h20,8'd4},        // R4 read path
        '{1'b0,1'b0,1'b1,1'b0,1'b1,1'b1,1'b0,1'b1,1'b1,4'hF,1'b0,9'h000,32'h0,1'b1,1'b1,32'h21,8'd4},
        '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,4'hF,1'b0,9'h030,32'h77777777,1'b1,1'b1,32'h30,8'd3}, // R3
        '{1'b0,1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,1'b1,1'b1,4'hF,1'b0,9'h000,32'h0,1'b0,1'b0,32'h0,8'd3},
        '{1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,4'hF,1'b0,9'h030,32'h0,1'b1,1'b1,32'h30,8'd3},
        '{1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,1'b1,1'b0,4'hF,1'b0,9'h030,32'h0,1'b0,1'b0,32'h0,8'd7},         // R7 empty write
        '{1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,4'hF,1'b0,9'h030,32'h0,1'b1,1'b1,32'h30,8'd6}         // R6 nothing stored
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        sel1_n, sel2, sel3_n, pstb_n, cstb_n, cont_n, burst_ilv;
    logic        gw_n, bwe_n, out_en_n;
    logic [3:0]  bsel_n;
    logic [8:0]  addr;
    logic [31:0] din, dout;
    logic        dout_en;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    sram_burst_ctrl uut (
        .clk(clk), .rst(rst), .sel1_n(sel1_n), .sel2(sel2), .sel3_n(sel3_n),
        .pstb_n(pstb_n), .cstb_n(cstb_n), .cont_n(cont_n), .burst_ilv(burst_ilv),
        .gw_n(gw_n), .bwe_n(bwe_n), .bsel_n(bsel_n), .out_en_n(out_en_n),
        .addr(addr), .din(din), .dout(dout), .dout_en(dout_en)
    );

    task automatic apply(input vec_t v);
        burst_ilv = v.ilv; sel1_n = v.s1n; sel2 = v.s2; sel3_n = v.s3n;
        pstb_n = v.pn; cstb_n = v.cn; cont_n = v.an; gw_n = v.gwn;
        bwe_n = v.bwen; bsel_n = v.bsn; out_en_n = v.oen; addr = v.ad; din = v.d;
    endtask

    task automatic check(input int rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL R%0d actual=%h expected=%h", rq, act, exp);
        end
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        apply('{1'b0,1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,1'b1,1'b1,4'hF,1'b0,9'h0,32'h0,1'b0,1'b0,32'h0,8'd0});
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(12, {31'b0, dout_en}, 32'd0);  // R12 reset state
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i]);
            @(posedge clk);
            @(negedge clk);
            check(VEC[i].rq, {31'b0, dout_en}, {31'b0, VEC[i].xen});
            if (VEC[i].ckd) check(VEC[i].rq, dout, VEC[i].xd);
        end

        // R8: output enable acts without a clock edge
        apply('{1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,4'hF,1'b0,9'h010,32'h0,1'b0,1'b0,32'h0,8'd0});
        @(posedge clk);
        @(negedge clk);
        check(8, {31'b0, dout_en}, 32'd1);
        out_en_n = 1'b1;
        #0.5;
        check(8, {31'b0, dout_en}, 32'd0);
        out_en_n = 1'b0;
        #0.5;
        check(8, {31'b0, dout_en}, 32'd1);

        // R12: reset in the middle of a read burst
        cstb_n = 1'b1; cont_n = 1'b0;
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check(12, {31'b0, dout_en}, 32'd0);
        rst = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check(12, {31'b0, dout_en}, 32'd0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule